// File: doc/BRIEF.md
# Dual-Mode Character Memory Write Controller

This block sits between a processor bus and an eight-entry character memory that a display scanner reads. Each entry holds a six-bit character code. A write happens while chip select is high and the active-low write strobe is low. Either signal can serve as the strobe. At the start of a write the block captures the mode and the addressing pins. At the end of the write it captures the data and stores it.

In random mode the three address pins name the entry. They are captured at the start of the write, so the same six bus lines can carry the address first and the data afterwards. In sequential mode an internal location counter picks the entry, starting at entry 0, the leftmost character. The address pins then take other roles. Pin 0 is a cascade enable. Pin 1 is an active-low clear. The full flag comes out on its own port. This lets several controllers share one bus: each one fills up in turn and then stops taking writes.

The scanner reads through a separate combinational port. A busy output tells the scanner when a storing write is in progress, so it can blank its outputs during that time. All logic runs on one system clock. The strobe and the clear pin are each synchronised through flip-flops, and the block acts on the edges of the synchronised strobe.

Top module: `chrmem_wr_ctrl`

## Requirements
- R1: The effective write is `cs_i & ~wr_n_i`. A pulse on `wr_n_i` while `cs_i` is low stores nothing. A pulse on `cs_i` while `wr_n_i` is held low performs a full write.
- R2: `mode_i` is captured at the start of each write: 1 selects sequential mode and 0 selects random mode. The latched mode changes only at the start of a write. It is 0 (random) after reset.
- R3: In random mode, `adr_i` is captured at the start of the write. Changing `adr_i` while the strobe is still active has no effect on where the data goes.
- R4: `data_i` is captured at the end of the write and stored in the selected entry. `rd_data_o` always shows the entry selected by `rd_adr_i`.
- R5: In sequential mode, a write stores at the counter's entry only if `adr_i[0]` was high at the start of the write and the full flag was clear. The counter starts at entry 0 and advances by one at the end of each store. Any other sequential write changes nothing.
- R6: The full flag sets at the end of the eighth sequential store. It stays set until a clear or a reset, and while it is set no sequential write stores.
- R7: While the latched mode is sequential, `adr_i[1]` low clears the counter and the full flag and sets every entry to 6'b100000 (0x20). While the latched mode is random, `adr_i[1]` low has no effect.
- R8: `full_o` is low from the start of any random-mode write. After a return to sequential mode, `full_o` reflects the full flag only from the end of the next write.
- R9: `wr_busy_o` is high from the start to the end of a write that will store. It stays low during a write that will not store.
- R10: After reset every entry reads 0x20, `full_o` is 0 and `wr_busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| mode_i | input | 1 | 1 = sequential mode, 0 = random mode; captured at the start of a write |
| adr_i | input | 3 | Random mode: entry address. Sequential mode: bit 0 = cascade enable, bit 1 = clear (active low) |
| data_i | input | 6 | Character code, captured at the end of a write |
| rd_adr_i | input | 3 | Scanner read address |
| rd_data_o | output | 6 | Entry selected by `rd_adr_i` |
| full_o | output | 1 | Sequential full flag, visible only in sequential mode |
| wr_busy_o | output | 1 | A storing write is in progress |

## Verification
The checker assumes three things about the inputs. Each strobe phase lasts longer than the synchroniser delay. `mode_i` and `adr_i` stay stable for at least three clocks after the strobe becomes active. `data_i` stays stable for at least three clocks after the strobe is released. With these, the checker can tie mode changes to start events and full-flag changes to end events. The stimulus keeps each strobe phase five clocks long and holds data six clocks past the release. It changes an address only two clocks after the capture point, and it leaves `adr_i[1]` high whenever the latched mode is sequential, except during the clear test.

// File: rtl/chrmem_pkg.sv
package chrmem_pkg;

    localparam int unsigned DEPTH_DEF  = 8;
    localparam int unsigned CODE_W_DEF = 6;

    typedef enum logic {
        MODE_RAND = 1'b0,
        MODE_SEQ  = 1'b1
    } mode_e;

    // Pin roles inside adr_i while in sequential mode
    localparam int unsigned PIN_SEN = 0;
    localparam int unsigned PIN_CLR = 1;

    // Location counter successor with wrap for non-power-of-two depths
    function automatic int unsigned loc_next(input int unsigned cur, input int unsigned depth);
        return (cur + 1 >= depth) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/chrmem_sync.sv
module chrmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/chrmem_locator.sv
module chrmem_locator
    import chrmem_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int LOC_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_evt,
    input  logic             end_evt,
    input  logic             clr_act,
    input  logic             mode_in,
    input  logic [LOC_W-1:0] adr_in,
    output mode_e            mode_q,
    output logic             pend_store,
    output logic [LOC_W-1:0] pend_loc,
    output logic [LOC_W-1:0] cnt_q,
    output logic             full_flag,
    output logic             full_vis,
    output logic             busy_q
);
    typedef struct packed {
        logic             store;
        logic [LOC_W-1:0] loc;
    } pend_t;

    pend_t pend_q, pend_d;

    always_comb begin
        if (mode_in) begin
            pend_d.store = adr_in[PIN_SEN] & ~full_flag;
            pend_d.loc   = cnt_q;
        end else begin
            pend_d.store = 1'b1;
            pend_d.loc   = adr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RAND;
            pend_q    <= '0;
            cnt_q     <= '0;
            full_flag <= 1'b0;
            full_vis  <= 1'b0;
            busy_q    <= 1'b0;
        end else begin
            if (start_evt) begin
                mode_q <= mode_e'(mode_in);
                pend_q <= pend_d;
                busy_q <= pend_d.store;
                if (!mode_in) full_vis <= 1'b0;
            end
            if (end_evt) begin
                busy_q <= 1'b0;
                if (mode_q == MODE_SEQ) begin
                    full_vis <= 1'b1;
                    if (pend_q.store) begin
                        cnt_q <= LOC_W'(loc_next(int'(cnt_q), DEPTH));
                        if (int'(cnt_q) == DEPTH - 1) full_flag <= 1'b1;
                    end
                end
            end
            if (clr_act) begin
                cnt_q     <= '0;
                full_flag <= 1'b0;
            end
        end
    end

    assign pend_store = pend_q.store;
    assign pend_loc   = pend_q.loc;
endmodule

// File: rtl/chrmem_store.sv
module chrmem_store #(
    parameter int DEPTH  = 8,
    parameter int CODE_W = 6,
    localparam int LOC_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [LOC_W-1:0]  wloc,
    input  logic [CODE_W-1:0] wdata,
    input  logic [LOC_W-1:0]  rloc,
    output logic [CODE_W-1:0] rdata
);
    localparam logic [CODE_W-1:0] BLANK = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] ent [DEPTH];

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (rst || clr)                        ent[e] <= BLANK;
            else if (we && (wloc == LOC_W'(e)))    ent[e] <= wdata;
        end
    end

    assign rdata = ent[rloc];
endmodule

// File: rtl/chrmem_wr_ctrl.sv
module chrmem_wr_ctrl
    import chrmem_pkg::*;
#(
    parameter int DEPTH       = DEPTH_DEF,
    parameter int CODE_W      = CODE_W_DEF,
    parameter int SYNC_STAGES = 2,
    localparam int LOC_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              wr_n_i,
    input  logic              mode_i,
    input  logic [LOC_W-1:0]  adr_i,
    input  logic [CODE_W-1:0] data_i,
    input  logic [LOC_W-1:0]  rd_adr_i,
    output logic [CODE_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              wr_busy_o
);
    logic wr_eff, wr_lvl, wr_prev;
    logic start_evt, end_evt;
    logic clr_lvl, clr_act;
    mode_e mode_q;
    logic pend_store;
    logic [LOC_W-1:0] pend_loc, cnt_q;
    logic full_flag, full_vis;

    assign wr_eff = cs_i & ~wr_n_i;

    chrmem_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .d(wr_eff), .q(wr_lvl)
    );

    chrmem_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(clk), .rst(rst), .d(~adr_i[PIN_CLR]), .q(clr_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= wr_lvl;
    end

    assign start_evt = wr_lvl & ~wr_prev;
    assign end_evt   = ~wr_lvl & wr_prev;
    assign clr_act   = clr_lvl & (mode_q == MODE_SEQ);

    chrmem_locator #(.DEPTH(DEPTH)) u_loc (
        .clk(clk), .rst(rst),
        .start_evt(start_evt), .end_evt(end_evt), .clr_act(clr_act),
        .mode_in(mode_i), .adr_in(adr_i),
        .mode_q(mode_q), .pend_store(pend_store), .pend_loc(pend_loc),
        .cnt_q(cnt_q), .full_flag(full_flag), .full_vis(full_vis),
        .busy_q(wr_busy_o)
    );

    chrmem_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_store (
        .clk(clk), .rst(rst), .clr(clr_act),
        .we(end_evt & pend_store), .wloc(pend_loc), .wdata(data_i),
        .rloc(rd_adr_i), .rdata(rd_data_o)
    );

    assign full_o = full_flag & full_vis;
endmodule

// File: rtl/chrmem_wr_chk.sv
module chrmem_wr_chk #(
    parameter int LOC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start_evt,
    input logic             end_evt,
    input logic             clr_act,
    input logic             wr_prev,
    input logic             mode_seq,
    input logic [LOC_W-1:0] cnt_q,
    input logic             full_flag,
    input logic             full_o,
    input logic             wr_busy_o
);
    // R2: the latched mode moves only on a write start
    assert_mode_at_start_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_seq != $past(mode_seq)) |-> $past(start_evt));

    // R5: the counter steps by one or returns to zero
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

    // R6: full flag stays set unless cleared
    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (full_flag && !clr_act) |=> full_flag);

    // R6: full flag rises only at a write end
    assert_full_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_flag) |-> $past(end_evt));

    // R7: clear empties counter and flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (cnt_q == '0 && !full_flag));

    // R8: full visible only in sequential mode
    assert_full_mode_R8: assert property (@(posedge clk) disable iff (rst)
        full_o |-> mode_seq);

    // R9: busy only inside an active synchronised strobe
    assert_busy_window_R9: assert property (@(posedge clk) disable iff (rst)
        wr_busy_o |-> wr_prev);
endmodule

bind chrmem_wr_ctrl chrmem_wr_chk #(.LOC_W(LOC_W)) u_chk (
    .clk(clk), .rst(rst),
    .start_evt(start_evt), .end_evt(end_evt), .clr_act(clr_act),
    .wr_prev(wr_prev), .mode_seq(mode_q == chrmem_pkg::MODE_SEQ),
    .cnt_q(cnt_q), .full_flag(full_flag), .full_o(full_o),
    .wr_busy_o(wr_busy_o)
);

// File: tb/chrmem_wr_ctrl_tb_top.sv
module chrmem_wr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_i = 1'b0, wr_n_i = 1'b1, mode_i = 1'b0;
    logic [2:0] adr_i = 3'b000, rd_adr_i = 3'b000;
    logic [5:0] data_i = 6'h00, rd_data_o;
    logic       full_o, wr_busy_o;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        int    kind;   // 0 memory entry, 1 full_o, 2 wr_busy_o
        int    a;
        int    v;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    chrmem_wr_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_i(cs_i), .wr_n_i(wr_n_i), .mode_i(mode_i),
        .adr_i(adr_i), .data_i(data_i), .rd_adr_i(rd_adr_i),
        .rd_data_o(rd_data_o), .full_o(full_o), .wr_busy_o(wr_busy_o)
    );

    task automatic push(input int k, input int a, input int v, input string r);
        exp_t it;
        it.kind = k; it.a = a; it.v = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic settle();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops expectations and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t it;
                int act;
                it = sb.pop_front();
                if (it.kind == 0) rd_adr_i = 3'(it.a);
                #1;
                case (it.kind)
                    0:       act = int'(rd_data_o);
                    1:       act = int'(full_o);
                    default: act = int'(wr_busy_o);
                endcase
                total++;
                if (act !== it.v) begin
                    bad++;
                    $display("FAIL %s kind=%0d idx=%0d act=%h exp=%h", it.req, it.kind, it.a, act, it.v);
                end
            end
        end
    end

    task automatic wr_begin(input logic m, input logic [2:0] a, input logic [5:0] d, input bit via_cs);
        @(negedge clk);
        mode_i = m; adr_i = a; data_i = d;
        if (via_cs) begin wr_n_i = 1'b0; @(negedge clk); cs_i = 1'b1; end
        else        begin cs_i = 1'b1; wr_n_i = 1'b0; end
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_end();
        cs_i = 1'b0; wr_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic m, input logic [2:0] a, input logic [5:0] d);
        wr_begin(m, a, d, 1'b0);
        wr_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10 reset state
        for (int e = 0; e < 8; e++) push(0, e, 'h20, "R10");
        push(1, 0, 0, "R10"); push(2, 0, 0, "R10");
        settle();

        // R4 R2 random writes; R9 busy inside a storing write
        wr_begin(1'b0, 3'd5, 6'h11, 1'b0);
        push(2, 0, 1, "R9");
        settle();
        wr_end();
        push(2, 0, 0, "R9");
        push(0, 5, 'h11, "R4");
        settle();
        wr(1'b0, 3'd0, 6'h3F);
        push(0, 0, 'h3F, "R4"); push(0, 5, 'h11, "R4");
        settle();

        // R3 address moves after capture
        wr_begin(1'b0, 3'd2, 6'h0A, 1'b0);
        adr_i = 3'd6;
        wr_end();
        push(0, 2, 'h0A, "R3"); push(0, 6, 'h20, "R3");
        settle();

        // R1 chip select gating, and chip select used as the strobe
        @(negedge clk);
        mode_i = 1'b0; adr_i = 3'd3; data_i = 6'h15; cs_i = 1'b0; wr_n_i = 1'b0;
        repeat (5) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (6) @(negedge clk);
        push(0, 3, 'h20, "R1");
        settle();
        wr_begin(1'b0, 3'd4, 6'h2A, 1'b1);
        wr_end();
        push(0, 4, 'h2A, "R1");
        settle();

        // R7 clear pin ignored in random mode
        adr_i = 3'b000;
        repeat (8) @(negedge clk);
        push(0, 0, 'h3F, "R7"); push(0, 5, 'h11, "R7");
        settle();

        // R5 sequential entry from location 0
        wr(1'b1, 3'b011, 6'h01);
        push(0, 0, 'h01, "R5"); push(0, 1, 'h20, "R5");
        settle();
        // R5 cascade enable low: no store, R9 busy stays low
        wr_begin(1'b1, 3'b010, 6'h07, 1'b0);
        push(2, 0, 0, "R9");
        settle();
        wr_end();
        push(0, 1, 'h20, "R5");
        settle();
        for (int n = 1; n < 7; n++) wr(1'b1, 3'b011, 6'(n + 1));
        push(1, 0, 0, "R6");
        settle();
        wr(1'b1, 3'b011, 6'h08);
        for (int e = 0; e < 8; e++) push(0, e, e + 1, "R5");
        push(1, 0, 1, "R6");
        settle();
        // R6 write while full is dropped
        wr_begin(1'b1, 3'b011, 6'h3C, 1'b0);
        push(2, 0, 0, "R6");
        settle();
        wr_end();
        push(0, 0, 'h01, "R6"); push(0, 7, 'h08, "R6"); push(1, 0, 1, "R6");
        settle();

        // R8 full hidden in random mode, returns after next sequential write end
        wr_begin(1'b0, 3'b110, 6'h33, 1'b0);
        push(1, 0, 0, "R8");
        settle();
        wr_end();
        push(1, 0, 0, "R8"); push(0, 6, 'h33, "R8");
        settle();
        wr_begin(1'b1, 3'b011, 6'h3D, 1'b0);
        push(1, 0, 0, "R8");
        settle();
        wr_end();
        push(1, 0, 1, "R8"); push(0, 0, 'h01, "R8");
        settle();

        // R7 clear in sequential mode
        adr_i = 3'b001;
        repeat (6) @(negedge clk);
        adr_i = 3'b011;
        repeat (6) @(negedge clk);
        for (int e = 0; e < 8; e++) push(0, e, 'h20, "R7");
        push(1, 0, 0, "R7");
        settle();
        wr(1'b1, 3'b011, 6'h12);
        push(0, 0, 'h12, "R7"); push(0, 1, 'h20, "R7");
        settle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule